// File: doc/BRIEF.md
# Interrupt Controller with Countdown Timer

This block collects interrupt lines for a small processor that handles interrupts through dedicated instructions. Each line carries an external request ORed with an internal source. Line 0 is a built-in countdown timer. Line 1 is an illegal-instruction or break event. Line 2 is a misaligned-access bus error. A static parameter chooses, line by line, whether a short pulse is remembered until service (latched) or whether the line is level-sensitive. A second static parameter disables lines for good. A run-time mask, fully set after reset, hides the remaining lines from the core.

The core talks to the block through single-cycle commands. A mask write or a timer write loads a new value, and the old value is visible on a read-back port in the same cycle. A handler-entry command takes every pending unmasked interrupt at once. That set is reported as one bitmask, and the end-of-interrupt lines for it stay high until the handler-return command. A wait request completes as soon as anything is pending and returns the pending set.

The controller is a three-state machine. IDLE raises the request while unmasked work is pending. It goes to SERVICE on the transition ENTER (handler entry with work pending) and back on RETURN (handler return). From either IDLE or SERVICE the transition FAULT leads to HALT: this happens when an illegal-instruction or bus-error event arrives while its own line is masked. HALT is left only by reset.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask reads back as all ones, the timer count reads 0, and irq_req, eoi and halt are 0.
- R2: A mask write shows the previous mask on mask_rdata in the same cycle. The new mask acts from the following cycle.
- R3: On a latched line, a one-cycle pulse makes the line pending from the next cycle. If unmasked, irq_req stays high until handler entry.
- R4: On a level line, pending follows the input with one cycle of delay, and dropping the input withdraws the request.
- R5: Handler entry in IDLE with unmasked work pending puts the whole pending unmasked set on irq_bits and eoi from the next cycle, and clears those latched pending bits.
- R6: In SERVICE irq_req is 0. Handler return clears irq_bits and eoi in the next cycle, and pending work then raises irq_req again.
- R7: A latched pulse arriving in the same cycle as handler entry stays pending after the entry.
- R8: A line whose bit is set in MASKED_LINES never becomes pending and never requests.
- R9: A timer write shows the old count on timer_rdata in the same cycle. A nonzero count drops by one each clock. The step from 1 to 0 makes line 0 pending. A count of 0 stays 0.
- R10: A line masked by the run-time mask still becomes pending (visible through wait_bits) but does not request until unmasked.
- R11: An illegal-instruction event (line 1) or bus-error event (line 2) makes that line pending if the line is unmasked. If the line is masked, the block enters HALT: halt is 1 from the next cycle, stays 1 and irq_req is 0.
- R12: wait_done is 1 only while wait_req is 1 and some line is pending. wait_bits then equals the pending set (masked lines included) and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ext | input | N_LINES | External interrupt lines |
| trap_illegal | input | 1 | Illegal-instruction or break event, ORed onto line 1 |
| trap_buserr | input | 1 | Misaligned-access event, ORed onto line 2 |
| mask_wr | input | 1 | Mask write command |
| mask_wdata | input | N_LINES | New mask (1 = disabled) |
| mask_rdata | output | N_LINES | Current (old) mask |
| timer_wr | input | 1 | Timer write command |
| timer_wdata | input | TIMER_W | New timer count |
| timer_rdata | output | TIMER_W | Current (old) timer count |
| handler_enter | input | 1 | Core enters the interrupt handler |
| handler_return | input | 1 | Core returns from the handler |
| wait_req | input | 1 | Core waits for any pending interrupt |
| wait_done | output | 1 | Wait may complete |
| wait_bits | output | N_LINES | Pending set returned to the wait |
| irq_req | output | 1 | Interrupt request to the core |
| irq_bits | output | N_LINES | Set being serviced |
| eoi | output | N_LINES | End-of-interrupt lines, high during service |
| halt | output | 1 | Core must stop |

## Verification
The hardest case to reach is a latched pulse that lands in the exact cycle of handler entry. The stimulus must be aligned so that the entry consumes other pending lines while the new pulse is set in the same clock. The bench arranges this by raising a fresh line on the same falling edge that asserts handler_enter. During SERVICE, with no request visible, it reads the pending set through the wait interface, which shows the new line kept and the serviced ones cleared. The timer corner cases are reached in a similar way: the bench counts clocks after a write to hit the 1-to-0 step, and it overwrites a running count to read back a mid-count value.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVICE = 2'd1,
        ST_HALT    = 2'd2
    } ctl_state_t;

    localparam int LINE_TIMER   = 0;
    localparam int LINE_ILLEGAL = 1;
    localparam int LINE_BUSERR  = 2;

endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
    parameter int TIMER_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_val,
    output logic [TIMER_W-1:0] count,
    output logic               fire
);
    localparam logic [TIMER_W-1:0] ONE  = TIMER_W'(1);
    localparam logic [TIMER_W-1:0] ZERO = '0;

    // expiry: the count is about to step from 1 to 0 with no reload
    assign fire = !load && (count == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n)              count <= ZERO;
        else if (load)           count <= load_val;
        else if (count != ZERO)  count <= count - ONE;
    end

    a_r9_fire_reaches_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (count == ZERO));

    a_r9_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (count == ZERO && !load) |=> (count == ZERO && !fire));

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int                 N_LINES       = 32,
    parameter logic [N_LINES-1:0] MASKED_LINES  = '0,
    parameter logic [N_LINES-1:0] LATCHED_LINES = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend
);
    localparam logic [N_LINES-1:0] KEEP = LATCHED_LINES & ~MASKED_LINES;

    logic [N_LINES-1:0] pend_nx;

    // per line: latched lines hold until cleared, level lines follow raw
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign pend_nx[i] = LATCHED_LINES[i] ? ((pend[i] & ~clr[i]) | raw[i])
                                             : raw[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nx & ~MASKED_LINES;
    end

    // R3 / R7: a latched pulse is always captured, even against a clear
    a_r3_pulse_captured: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & KEEP) != '0) |=> ((pend & $past(raw & KEEP)) == $past(raw & KEEP)));

    // R8: permanently disabled lines never show up
    a_r8_never_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & MASKED_LINES) == '0);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int                 N_LINES       = 32,
    parameter int                 TIMER_W       = 32,
    parameter logic [N_LINES-1:0] MASKED_LINES  = '0,
    parameter logic [N_LINES-1:0] LATCHED_LINES = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_ext,
    input  logic               trap_illegal,
    input  logic               trap_buserr,
    input  logic               mask_wr,
    input  logic [N_LINES-1:0] mask_wdata,
    output logic [N_LINES-1:0] mask_rdata,
    input  logic               timer_wr,
    input  logic [TIMER_W-1:0] timer_wdata,
    output logic [TIMER_W-1:0] timer_rdata,
    input  logic               handler_enter,
    input  logic               handler_return,
    input  logic               wait_req,
    output logic               wait_done,
    output logic [N_LINES-1:0] wait_bits,
    output logic               irq_req,
    output logic [N_LINES-1:0] irq_bits,
    output logic [N_LINES-1:0] eoi,
    output logic               halt
);
    ctl_state_t         state, state_nx;
    logic [N_LINES-1:0] mask_q, mask_eff;
    logic [N_LINES-1:0] src, pend, live, clr, serve;
    logic               tmr_fire, fault, take;

    irq_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_wr),
        .load_val (timer_wdata),
        .count    (timer_rdata),
        .fire     (tmr_fire)
    );

    always_comb begin
        src               = irq_ext;
        src[LINE_TIMER]   = irq_ext[LINE_TIMER]   | tmr_fire;
        src[LINE_ILLEGAL] = irq_ext[LINE_ILLEGAL] | trap_illegal;
        src[LINE_BUSERR]  = irq_ext[LINE_BUSERR]  | trap_buserr;
    end

    irq_pending #(
        .N_LINES       (N_LINES),
        .MASKED_LINES  (MASKED_LINES),
        .LATCHED_LINES (LATCHED_LINES)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src),
        .clr   (clr),
        .pend  (pend)
    );

    // run-time mask, all lines disabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata;
    end
    assign mask_rdata = mask_q;
    assign mask_eff   = mask_q | MASKED_LINES;

    assign live  = pend & ~mask_eff;
    assign fault = (trap_illegal && mask_eff[LINE_ILLEGAL]) ||
                   (trap_buserr  && mask_eff[LINE_BUSERR]);
    assign take  = (state == ST_IDLE) && handler_enter && (live != '0) && !fault;
    assign clr   = take ? live : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions ENTER, RETURN, FAULT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fault)     state_nx = ST_HALT;
                else if (take) state_nx = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (fault)               state_nx = ST_HALT;
                else if (handler_return) state_nx = ST_IDLE;
            end
            ST_HALT: state_nx = ST_HALT;
        endcase
    end

    // serviced set, held for the whole handler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serve <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) serve <= live;
                end
                ST_SERVICE: begin
                    if (fault || handler_return) serve <= '0;
                end
                ST_HALT: serve <= '0;
            endcase
        end
    end

    assign irq_bits  = serve;
    assign eoi       = serve;
    assign irq_req   = (state == ST_IDLE) && (live != '0);
    assign halt      = (state == ST_HALT);
    assign wait_done = wait_req && (pend != '0);
    assign wait_bits = wait_done ? pend : '0;

    a_r5_entry_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_enter && irq_req && !trap_illegal && !trap_buserr) |=> (eoi != '0));

    a_r5_eoi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && !handler_return && !fault) |=> $stable(eoi));

    a_r6_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && handler_return) |=> (eoi == '0 && irq_bits == '0));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && !irq_req));

endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;

    localparam int N = 32;
    localparam int T = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_ext, mask_wdata, mask_rdata, wait_bits, irq_bits, eoi;
    logic [T-1:0] timer_wdata, timer_rdata;
    logic         trap_illegal, trap_buserr, mask_wr, timer_wr;
    logic         handler_enter, handler_return, wait_req, wait_done, irq_req, halt;

    always #4 clk = ~clk;

    irq_ctrl #(
        .N_LINES       (N),
        .TIMER_W       (T),
        .MASKED_LINES  (32'h8000_0000),
        .LATCHED_LINES (32'hFFFF_FF0F)
    ) dut (
        .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext),
        .trap_illegal(trap_illegal), .trap_buserr(trap_buserr),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .timer_wr(timer_wr), .timer_wdata(timer_wdata), .timer_rdata(timer_rdata),
        .handler_enter(handler_enter), .handler_return(handler_return),
        .wait_req(wait_req), .wait_done(wait_done), .wait_bits(wait_bits),
        .irq_req(irq_req), .irq_bits(irq_bits), .eoi(eoi), .halt(halt)
    );

    typedef enum int {O_REQ, O_BITS, O_EOI, O_HALT, O_MASK, O_TMR, O_WDONE, O_WBITS} obs_t;
    typedef struct {
        obs_t        sel;
        logic [31:0] val;
        string       req;
    } item_t;

    item_t queue_q[$];
    event  check_ev;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    function automatic logic [31:0] b(int i);
        return 32'd1 << i;
    endfunction

    task automatic expect_val(obs_t sel, logic [31:0] val, string req);
        item_t it;
        it.sel = sel; it.val = val; it.req = req;
        queue_q.push_back(it);
    endtask

    task automatic check_now();
        -> check_ev;
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares after inputs settle
    initial begin
        forever begin
            @(check_ev);
            #1;
            while (queue_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = queue_q.pop_front();
                unique case (it.sel)
                    O_REQ:   act = {31'd0, irq_req};
                    O_BITS:  act = irq_bits;
                    O_EOI:   act = eoi;
                    O_HALT:  act = {31'd0, halt};
                    O_MASK:  act = mask_rdata;
                    O_TMR:   act = timer_rdata;
                    O_WDONE: act = {31'd0, wait_done};
                    O_WBITS: act = wait_bits;
                endcase
                total++;
                if (act !== it.val) begin
                    bad++;
                    $display("FAIL %s %s actual=%h expected=%h", it.req, it.sel.name(), act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; irq_ext = '0; trap_illegal = 0; trap_buserr = 0;
        mask_wr = 0; mask_wdata = '0; timer_wr = 0; timer_wdata = '0;
        handler_enter = 0; handler_return = 0; wait_req = 0;
        repeat (3) nedge();
        rst_n = 1;

        // R1: reset state, and unmask everything
        mask_wr = 1; mask_wdata = '0;
        expect_val(O_MASK, 32'hFFFF_FFFF, "R1"); expect_val(O_REQ, 0, "R1");
        expect_val(O_EOI, 0, "R1"); expect_val(O_HALT, 0, "R1"); expect_val(O_TMR, 0, "R1");
        check_now();
        nedge(); mask_wr = 0; irq_ext = b(9);
        nedge(); irq_ext = '0;
        expect_val(O_REQ, 1, "R3"); check_now();
        repeat (3) nedge();
        expect_val(O_REQ, 1, "R3 held"); check_now();

        // R5 / R7: pulse 12, level 5, then enter with pulse 20 in the entry cycle
        irq_ext = b(12) | b(5);
        nedge(); irq_ext = b(5) | b(20); handler_enter = 1;
        nedge(); handler_enter = 0; irq_ext = b(5); wait_req = 1;
        expect_val(O_BITS, b(9) | b(12) | b(5), "R5");
        expect_val(O_EOI,  b(9) | b(12) | b(5), "R5");
        expect_val(O_REQ, 0, "R6");
        expect_val(O_WBITS, b(20) | b(5), "R7");
        expect_val(O_WDONE, 1, "R12");
        check_now();
        nedge(); wait_req = 0; irq_ext = '0; handler_return = 1;
        nedge(); handler_return = 0;
        expect_val(O_EOI, 0, "R6"); expect_val(O_BITS, 0, "R6"); expect_val(O_REQ, 1, "R6");
        check_now();
        handler_enter = 1;
        nedge(); handler_enter = 0;
        expect_val(O_BITS, b(20), "R7"); check_now();
        handler_return = 1;
        nedge(); handler_return = 0;
        expect_val(O_REQ, 0, "R5 cleared"); check_now();

        // R4: level line 6
        irq_ext = b(6);
        nedge(); expect_val(O_REQ, 1, "R4"); check_now();
        irq_ext = '0;
        nedge(); expect_val(O_REQ, 0, "R4"); check_now();

        // R8: permanently disabled line 31
        irq_ext = b(31);
        nedge(); irq_ext = '0; wait_req = 1;
        expect_val(O_REQ, 0, "R8"); expect_val(O_WDONE, 0, "R12"); expect_val(O_WBITS, 0, "R12");
        check_now();
        nedge(); wait_req = 0;

        // R2 / R10: run-time mask
        mask_wr = 1; mask_wdata = b(15);
        expect_val(O_MASK, 0, "R2"); check_now();
        nedge(); mask_wr = 0; irq_ext = b(15);
        nedge(); irq_ext = '0; wait_req = 1;
        expect_val(O_REQ, 0, "R10"); expect_val(O_WBITS, b(15), "R10"); check_now();
        nedge(); wait_req = 0; mask_wr = 1; mask_wdata = '0;
        expect_val(O_MASK, b(15), "R2"); expect_val(O_REQ, 0, "R2"); check_now();
        nedge(); mask_wr = 0;
        expect_val(O_REQ, 1, "R2"); check_now();
        handler_enter = 1;
        nedge(); handler_enter = 0;
        expect_val(O_BITS, b(15), "R10"); check_now();
        handler_return = 1;
        nedge(); handler_return = 0;

        // R9: timer expiry
        timer_wr = 1; timer_wdata = 5;
        expect_val(O_TMR, 0, "R9"); check_now();
        nedge(); timer_wr = 0;
        expect_val(O_TMR, 5, "R9"); check_now();
        repeat (3) nedge();
        expect_val(O_TMR, 2, "R9"); check_now();
        nedge(); expect_val(O_TMR, 1, "R9"); expect_val(O_REQ, 0, "R9"); check_now();
        nedge(); expect_val(O_TMR, 0, "R9"); expect_val(O_REQ, 1, "R9"); check_now();
        handler_enter = 1;
        nedge(); handler_enter = 0;
        expect_val(O_BITS, b(0), "R9"); check_now();
        handler_return = 1;
        nedge(); handler_return = 0;
        nedge(); expect_val(O_REQ, 0, "R9"); expect_val(O_TMR, 0, "R9"); check_now();
        timer_wr = 1; timer_wdata = 100;
        nedge(); timer_wr = 0;
        nedge(); timer_wr = 1; timer_wdata = 0;
        expect_val(O_TMR, 99, "R9"); check_now();
        nedge(); timer_wr = 0;
        repeat (3) nedge();
        expect_val(O_TMR, 0, "R9"); expect_val(O_REQ, 0, "R9"); check_now();

        // R11: unmasked fault is an interrupt, masked fault halts
        trap_illegal = 1;
        nedge(); trap_illegal = 0;
        expect_val(O_HALT, 0, "R11"); expect_val(O_REQ, 1, "R11"); check_now();
        handler_enter = 1;
        nedge(); handler_enter = 0;
        expect_val(O_BITS, b(1), "R11"); check_now();
        handler_return = 1;
        nedge(); handler_return = 0; mask_wr = 1; mask_wdata = b(2);
        nedge(); mask_wr = 0; trap_buserr = 1;
        nedge(); trap_buserr = 0;
        expect_val(O_HALT, 1, "R11"); expect_val(O_REQ, 0, "R11"); check_now();
        repeat (3) nedge();
        expect_val(O_HALT, 1, "R11"); expect_val(O_EOI, 0, "R11"); check_now();

        nedge();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule